// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block keeps wall-clock time as packed BCD registers: hundredths of a second, seconds, minutes, hours (24-hour form), day of week, date, month and year, plus a century flag. A 100 Hz strobe advances the count. The hundredths field carries into seconds, and so on up the chain, to the year and the century flag. A simple synchronous register port with a byte address gives access to every field. Writes take effect at the clock edge, and reads are combinational from the address.

Two control bits live in the spare top bits of the time registers. A halt bit in the seconds register freezes all counting. A century-enable bit in the hours register decides whether the century flag flips when the year wraps. An oscillator-fail flag sits in the minutes register and is also visible at a second address. Any missing oscillation sets it, and so does the halt bit. Software can only clear it, and only while the oscillator runs.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset every time field reads 00h, the halt bit, century-enable and century flag read 0, and the oscillator-fail flag reads 1.
- R2: Each tick while not halted raises hundredths by one in BCD. The wraps are hundredths 99→00, seconds 59→00, minutes 59→00 and hours 23→00, and each wrap advances the next field once.
- R3: Day of week (address 03h, bits 2:0) advances at every hours wrap, 7→1 and otherwise +1, independent of the date.
- R4: At an hours wrap, a date equal to the month length goes to 01 and the month advances, otherwise the date goes up by one. Months 04, 06, 09 and 11 have 30 days. February has 29 days when the BCD year is divisible by 4 and 28 otherwise. Every other month has 31 days. Month 12→01 advances the year.
- R5: The year wraps 99→00. At that wrap the century flag (address 02h bit 6) inverts if century-enable (address 02h bit 7) is 1, and holds otherwise.
- R6: Address 00h bit 7 is the halt bit. While it is 1, ticks change no field.
- R7: The oscillator-fail flag (address 01h bit 7) becomes 1 in the cycle after a clock where the oscillator-alive input is low or the halt bit is 1. Writing 0 to it clears it only when neither of those holds. Writing 1 leaves it unchanged.
- R8: Address 09h bit 7 reads and clears the same flag under the same rules. Its other bits read 0.
- R9: A write to addresses 00h–06h loads that field and sets hundredths to 00, and a tick in the same cycle is dropped. Must-be-zero bits are not stored: bits 7:6 at 04h, bits 7:5 at 05h and bits 7:3 at 03h read 0.
- R10: Hundredths read at address 1Fh. Writes there change nothing, and a tick in that cycle still counts.
- R11: Addresses with no register read 00h, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_100hz | input | 1 | One-cycle strobe, 100 per second |
| osc_alive | input | 1 | High while the oscillator is seen toggling |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |

## Verification
A register write and a 100 Hz tick can land in the same cycle. The bench drives both together on a time field, on the read-only hundredths address and on the flag mirror. The model expects the time-field write to win and drop the tick, and expects the other two cases to count normally. The flag is also driven by a clear write and a dead oscillator in the same cycle, and the model requires the flag to stay set. Every register is read back after each clock and compared.

// File: rtl/rtc_bcd_core.sv
`timescale 1ns/1ps
module rtc_bcd_core #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_100hz,
  input  logic              osc_alive,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam logic [ADDR_W-1:0] A_SEC = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MIN = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_HR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DOW = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_DT  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MO  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_YR  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_OFM = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_HS  = ADDR_W'(31);

  logic [7:0] hs, yr;
  logic [6:0] sec, mn;
  logic [5:0] hr, date;
  logic [4:0] mon;
  logic [2:0] dow;
  logic       stop, of, ceb, cb;

  wire time_wr = wr_en && (addr <= A_YR);
  wire running = osc_alive && !stop;
  wire of_clr  = wr_en && (addr == A_MIN || addr == A_OFM) && !wdata[7];

  wire [7:0] hs_inc  = (hs[3:0] == 4'd9)   ? {hs[7:4] + 4'd1, 4'd0}   : {hs[7:4], hs[3:0] + 4'd1};
  wire [6:0] sec_inc = (sec[3:0] == 4'd9)  ? {sec[6:4] + 3'd1, 4'd0}  : {sec[6:4], sec[3:0] + 4'd1};
  wire [6:0] mn_inc  = (mn[3:0] == 4'd9)   ? {mn[6:4] + 3'd1, 4'd0}   : {mn[6:4], mn[3:0] + 4'd1};
  wire [5:0] hr_inc  = (hr[3:0] == 4'd9)   ? {hr[5:4] + 2'd1, 4'd0}   : {hr[5:4], hr[3:0] + 4'd1};
  wire [5:0] dt_inc  = (date[3:0] == 4'd9) ? {date[5:4] + 2'd1, 4'd0} : {date[5:4], date[3:0] + 4'd1};
  wire [4:0] mo_inc  = (mon[3:0] == 4'd9)  ? 5'h10 : {mon[4], mon[3:0] + 4'd1};
  wire [7:0] yr_inc  = (yr[3:0] == 4'd9)   ? {yr[7:4] + 4'd1, 4'd0}   : {yr[7:4], yr[3:0] + 4'd1};

  wire leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                    : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
  logic [5:0] month_len;
  always_comb begin
    case (mon)
      5'h02:                      month_len = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: month_len = 6'h30;
      default:                    month_len = 6'h31;
    endcase
  end

  wire c_hs  = tick_100hz && !stop && !time_wr;
  wire c_sec = c_hs  && (hs == 8'h99);
  wire c_min = c_sec && (sec == 7'h59);
  wire c_hr  = c_min && (mn == 7'h59);
  wire c_day = c_hr  && (hr == 6'h23);
  wire c_mon = c_day && (date == month_len);
  wire c_yr  = c_mon && (mon == 5'h12);
  wire c_cen = c_yr  && (yr == 8'h99) && ceb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs <= '0; sec <= '0; mn <= '0; hr <= '0; dow <= '0;
      date <= '0; mon <= '0; yr <= '0;
      stop <= 1'b0; ceb <= 1'b0; cb <= 1'b0; of <= 1'b1;
    end else begin
      if (!running)    of <= 1'b1;
      else if (of_clr) of <= 1'b0;

      if (time_wr)   hs <= '0;
      else if (c_hs) hs <= c_sec ? 8'h00 : hs_inc;

      if (wr_en && addr == A_SEC) begin
        stop <= wdata[7];
        sec  <= wdata[6:0];
      end else if (c_sec) sec <= c_min ? 7'h00 : sec_inc;

      if (wr_en && addr == A_MIN) mn <= wdata[6:0];
      else if (c_min)             mn <= c_hr ? 7'h00 : mn_inc;

      if (wr_en && addr == A_HR) begin
        ceb <= wdata[7];
        cb  <= wdata[6];
        hr  <= wdata[5:0];
      end else begin
        if (c_hr)  hr <= c_day ? 6'h00 : hr_inc;
        if (c_cen) cb <= !cb;
      end

      if (wr_en && addr == A_DOW) dow <= wdata[2:0];
      else if (c_day)             dow <= (dow == 3'd7) ? 3'd1 : dow + 3'd1;

      if (wr_en && addr == A_DT) date <= wdata[5:0];
      else if (c_day)            date <= c_mon ? 6'h01 : dt_inc;

      if (wr_en && addr == A_MO) mon <= wdata[4:0];
      else if (c_mon)            mon <= c_yr ? 5'h01 : mo_inc;

      if (wr_en && addr == A_YR) yr <= wdata;
      else if (c_yr)             yr <= (yr == 8'h99) ? 8'h00 : yr_inc;
    end
  end

  always_comb begin
    case (addr)
      A_SEC:   rdata = {stop, sec};
      A_MIN:   rdata = {of, mn};
      A_HR:    rdata = {ceb, cb, hr};
      A_DOW:   rdata = {5'b0, dow};
      A_DT:    rdata = {2'b0, date};
      A_MO:    rdata = {3'b0, mon};
      A_YR:    rdata = yr;
      A_OFM:   rdata = {of, 7'b0};
      A_HS:    rdata = hs;
      default: rdata = 8'h00;
    endcase
  end
endmodule

module rtc_bcd_core_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_100hz,
  input logic              osc_alive,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        hs,
  input logic              stop,
  input logic              of,
  input logic              ceb,
  input logic              cb
);
  assert_hs_is_bcd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hs[3:0] <= 4'd9 && hs[7:4] <= 4'd9);

  assert_cb_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ceb && !(wr_en && addr == ADDR_W'(2)) |=> $stable(cb));

  assert_halt_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !(wr_en && addr <= ADDR_W'(6)) |=> $stable(hs));

  assert_flag_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_alive || stop) |=> of);

  assert_flag_not_set_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !of && osc_alive && !stop && wr_en && (addr == ADDR_W'(1) || addr == ADDR_W'(9)) |=> !of);

  assert_write_clears_hs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr <= ADDR_W'(6) |=> hs == 8'h00);

  assert_hs_readonly_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == ADDR_W'(31) && !tick_100hz |=> $stable(hs));
endmodule

bind rtc_bcd_core rtc_bcd_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .osc_alive(osc_alive),
  .wr_en(wr_en), .addr(addr), .hs(hs), .stop(stop), .of(of), .ceb(ceb), .cb(cb)
);

// File: tb/rtc_bcd_core_test.sv
`timescale 1ns/1ps
module rtc_bcd_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_100hz = 1'b0;
  logic       osc_alive = 1'b1;
  logic       wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  rtc_bcd_core #(.ADDR_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .osc_alive(osc_alive),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  string cur = "R1";

  int m_hs, m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr;
  bit m_stop, m_of, m_ceb, m_cb;

  function automatic int tobcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction
  function automatic int frombcd(int v);
    return ((v >> 4) & 15) * 10 + (v & 15);
  endfunction
  function automatic int days_in(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int expect_rd(int a);
    case (a)
      0:  return (int'(m_stop) << 7) | tobcd(m_sec);
      1:  return (int'(m_of) << 7) | tobcd(m_min);
      2:  return (int'(m_ceb) << 7) | (int'(m_cb) << 6) | tobcd(m_hr);
      3:  return m_dow;
      4:  return tobcd(m_date);
      5:  return tobcd(m_mon);
      6:  return tobcd(m_yr);
      9:  return int'(m_of) << 7;
      31: return tobcd(m_hs);
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_hs = 0; m_sec = 0; m_min = 0; m_hr = 0; m_dow = 0; m_date = 0; m_mon = 0; m_yr = 0;
    m_stop = 0; m_ceb = 0; m_cb = 0; m_of = 1;
  endtask

  task automatic model_clk(bit w, int a, int d, bit t, bit osc);
    bit nof;
    if (!osc || m_stop) nof = 1;
    else if (w && (a == 1 || a == 9) && !d[7]) nof = 0;
    else nof = m_of;
    if (w && a <= 6) begin
      m_hs = 0;
      case (a)
        0: begin m_stop = d[7]; m_sec = frombcd(d & 8'h7F); end
        1: m_min = frombcd(d & 8'h7F);
        2: begin m_ceb = d[7]; m_cb = d[6]; m_hr = frombcd(d & 8'h3F); end
        3: m_dow = d & 7;
        4: m_date = frombcd(d & 8'h3F);
        5: m_mon = frombcd(d & 8'h1F);
        default: m_yr = frombcd(d);
      endcase
    end else if (t && !m_stop) begin
      m_hs++;
      if (m_hs == 100) begin
        m_hs = 0; m_sec++;
        if (m_sec == 60) begin
          m_sec = 0; m_min++;
          if (m_min == 60) begin
            m_min = 0; m_hr++;
            if (m_hr == 24) begin
              m_hr = 0;
              m_dow = (m_dow == 7) ? 1 : m_dow + 1;
              if (m_date == days_in(m_mon, m_yr)) begin
                m_date = 1;
                if (m_mon == 12) begin
                  m_mon = 1;
                  if (m_yr == 99) begin
                    m_yr = 0;
                    if (m_ceb) m_cb = !m_cb;
                  end else m_yr++;
                end else m_mon++;
              end else m_date++;
            end
          end
        end
      end
    end
    m_of = nof;
  endtask

  task automatic compare_all();
    int alist[11] = '{0, 1, 2, 3, 4, 5, 6, 9, 31, 10, 21};
    foreach (alist[i]) begin
      int e;
      addr = 5'(alist[i]);
      #0.1;
      e = expect_rd(alist[i]);
      checks++;
      if (int'(rdata) != e) begin
        errors++;
        $display("FAIL %s addr=%02h actual=%02h expected=%02h", cur, alist[i], rdata, e);
      end
    end
  endtask

  task automatic step(bit w, int a, int d, bit t);
    @(negedge clk);
    compare_all();
    wr_en = w; addr = 5'(a); wdata = 8'(d); tick_100hz = t;
    @(posedge clk);
    model_clk(w, a, d, t, osc_alive);
    #0.5;
    wr_en = 1'b0; tick_100hz = 1'b0;
  endtask

  task automatic wr(int a, int d);
    step(1, a, d, 0);
  endtask
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1);
  endtask
  task automatic to_midnight(int dt, int mo, int y, int hrb);
    wr(6, y); wr(5, mo); wr(4, dt); wr(2, hrb); wr(1, 8'h59); wr(0, 8'h59);
    ticks(100);
    step(0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(4.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    cur = "R1";
    step(0, 0, 0, 0); step(0, 0, 0, 0);

    cur = "R7";
    wr(1, 8'h00); step(0, 0, 0, 0);

    cur = "R2";
    ticks(120);
    wr(0, 8'h59); wr(1, 8'h59); wr(2, 8'h23);
    ticks(100);

    cur = "R3";
    wr(3, 7); to_midnight(8'h15, 8'h06, 8'h10, 8'h23);
    to_midnight(8'h16, 8'h06, 8'h10, 8'h23);

    cur = "R4";
    to_midnight(8'h28, 8'h02, 8'h03, 8'h23);
    to_midnight(8'h28, 8'h02, 8'h04, 8'h23);
    to_midnight(8'h29, 8'h02, 8'h04, 8'h23);
    to_midnight(8'h28, 8'h02, 8'h00, 8'h23);
    to_midnight(8'h30, 8'h04, 8'h21, 8'h23);
    to_midnight(8'h30, 8'h11, 8'h21, 8'h23);
    to_midnight(8'h30, 8'h10, 8'h21, 8'h23);
    to_midnight(8'h31, 8'h12, 8'h98, 8'h23);

    cur = "R5";
    to_midnight(8'h31, 8'h12, 8'h99, 8'hA3);
    to_midnight(8'h31, 8'h12, 8'h99, 8'hA3);
    to_midnight(8'h31, 8'h12, 8'h99, 8'h63);

    cur = "R6";
    wr(0, 8'hB0); ticks(50);
    wr(0, 8'h30); ticks(20);

    cur = "R8";
    wr(9, 8'h80); step(0, 0, 0, 0);
    wr(9, 8'h00); ticks(3);

    cur = "R7";
    osc_alive = 1'b0; step(0, 0, 0, 0);
    wr(1, 8'h12); step(0, 0, 0, 0);
    osc_alive = 1'b1; step(0, 0, 0, 0);
    wr(1, 8'h92); step(0, 0, 0, 0);
    wr(1, 8'h12); step(0, 0, 0, 0);
    wr(1, 8'h93); ticks(2);
    osc_alive = 1'b0; wr(9, 8'h00);
    osc_alive = 1'b1; step(0, 0, 0, 0);
    wr(9, 8'h00); step(0, 0, 0, 0);

    cur = "R9";
    ticks(55);
    step(1, 0, 8'h10, 1); ticks(40);
    step(1, 6, 8'h21, 1); ticks(99);
    wr(3, 8'hFF); wr(5, 8'hF2); wr(4, 8'hC7); step(0, 0, 0, 0);

    cur = "R10";
    ticks(37);
    step(1, 31, 8'h55, 1); step(1, 31, 8'h00, 0);
    step(1, 9, 8'h80, 1); ticks(2);

    cur = "R11";
    wr(10, 8'hFF); wr(21, 8'h5A); step(0, 0, 0, 1);
    step(0, 0, 0, 0);

    summary();
    $finish;
  end
endmodule